// File: doc/BRIEF.md
# Writeback Pixel Format Packer

The packer sits on the memory side of a writeback path. It takes one 32-bit pixel per handshake, with alpha in the top byte, then red, green and blue in the lowest byte. It turns each pixel into the byte layout named by a 4-bit format code and gathers those bytes into 32-bit memory words. Each word carries a 4-bit byte strobe. Supported depths are 16 bits (4444 and 565), 24 bits (888) and 32 bits (8888). The channel order within each depth is picked by the code.

The format code, the alpha controls and the per-lane store mask are static configuration. They are held constant while a line is streamed. The pixel source marks the final pixel of each line. The packer then empties any partly filled word, so the next line starts on a fresh word. Two register stages make up the block: a conversion stage and a gathering stage. Both honour backpressure from the word consumer.

Top module: `wb_pixel_packer`

## Requirements
- R1: After reset the block presents no output word (`out_valid` low) and accepts a pixel (`in_ready` high).
- R2: Codes 12, 13, 14 and 15 give 4-byte pixels ordered, from byte 3 down to byte 0, as A-B-G-R, A-R-G-B, B-G-R-A and R-G-B-A.
- R3: Codes 0, 1, 2 and 3 give 16-bit pixels with the same four orderings as R2, one nibble per channel, nibble 3 highest. Each nibble is the top four bits of its channel.
- R4: Codes 6 and 7 give 16-bit pixels: B[7:3],G[7:2],R[7:3] for 6 and R[7:3],G[7:2],B[7:3] for 7, from bit 15 down to bit 0.
- R5: Codes 8 and 9 give 3-byte pixels, B-G-R and R-G-B from byte 2 down to byte 0. Four such pixels fill exactly three words, with bytes placed in increasing lane order across word boundaries.
- R6: In 16-bit formats a word holds two pixels, and the earlier pixel sits in bits 15:0.
- R7: With alpha enable set, the alpha channel is stored as received when invert is clear, and bitwise inverted when invert is set.
- R8: With alpha enable clear, every alpha bit is the complement of the invert bit (all ones when invert is clear, all zeros when set).
- R9: Codes 4, 5, 10 and 11 produce the same output as code 13.
- R10: At the end of a line, a partly filled word is sent with strobes set only for its filled lanes. When a final 3-byte pixel crosses a word boundary, two words are sent.
- R11: Strobe lane k is the AND of "lane k holds data" and bit k of the store mask. A masked lane is never strobed.
- R12: Under backpressure no word is lost or repeated. While `out_valid` is high and `out_ready` low, `out_data` and `out_strb` hold their values.
- R13: No bytes carry over from one line to the next: each line's first pixel starts at lane 0 of a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 4 | Output format code |
| cfg_alpha_en | input | 1 | Store the received alpha |
| cfg_alpha_inv | input | 1 | Invert stored alpha, or select the fill value |
| cfg_byte_en | input | 4 | Store mask, one bit per byte lane |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted this cycle when valid |
| in_argb | input | 32 | Pixel: A[31:24] R[23:16] G[15:8] B[7:0] |
| in_eol | input | 1 | Pixel is the last of its line |
| out_valid | output | 1 | Word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Packed memory word, lane 0 in bits 7:0 |
| out_strb | output | 4 | Byte strobes for the word |

## Verification
A wrong leftover count or a stale accumulator in the gathering stage appears at the ports as misplaced lanes. It shows in the first word after the fault, or as a word arriving too early or too late, and the bench catches it in the word count for the line. A fault in the format decode corrupts the very next word the pixel reaches. A lost end-of-line flush leaves the expected word missing. The line then stalls and the bench flags the missing word at that line's check. Holding the consumer off on chosen cycles exposes any change to a word that is still waiting.

// File: rtl/wbpp_pkg.sv
package wbpp_pkg;

  localparam int unsigned CH_W       = 8;
  localparam int unsigned PIX_W      = 4 * CH_W;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = WORD_BYTES * 8;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned NB_W       = 3;  // byte count 0..7
  localparam int unsigned LEFT_W     = 2;  // leftover bytes 0..3
  localparam int unsigned ACC_W      = (WORD_BYTES - 1) * 8;
  localparam int unsigned COMB_W     = ACC_W + WORD_W;

  typedef enum logic [1:0] {
    FK_4444,
    FK_565,
    FK_888,
    FK_8888
  } fmt_kind_e;

  // Unused codes fold onto ARGB8888.
  function automatic logic [CODE_W-1:0] norm_code(input logic [CODE_W-1:0] c);
    case (c)
      4'd4, 4'd5, 4'd10, 4'd11: norm_code = 4'd13;
      default:                  norm_code = c;
    endcase
  endfunction

  function automatic fmt_kind_e kind_of(input logic [CODE_W-1:0] c);
    case (norm_code(c))
      4'd0, 4'd1, 4'd2, 4'd3: kind_of = FK_4444;
      4'd6, 4'd7:             kind_of = FK_565;
      4'd8, 4'd9:             kind_of = FK_888;
      default:                kind_of = FK_8888;
    endcase
  endfunction

  function automatic logic [NB_W-1:0] nbytes_of(input fmt_kind_e k);
    case (k)
      FK_4444, FK_565: nbytes_of = 3'd2;
      FK_888:          nbytes_of = 3'd3;
      default:         nbytes_of = 3'd4;
    endcase
  endfunction

  // Strobe pattern for the lowest n lanes.
  function automatic logic [WORD_BYTES-1:0] lane_mask(input logic [NB_W-1:0] n);
    case (n)
      3'd0:    lane_mask = 4'b0000;
      3'd1:    lane_mask = 4'b0001;
      3'd2:    lane_mask = 4'b0011;
      3'd3:    lane_mask = 4'b0111;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // Effective alpha: stored, inverted, or filled.
  function automatic logic [CH_W-1:0] alpha_eff(input logic a_en, input logic a_inv,
                                                input logic [CH_W-1:0] a);
    if (a_en) alpha_eff = a_inv ? ~a : a;
    else      alpha_eff = {CH_W{~a_inv}};
  endfunction

  // Repack one ARGB pixel; result is right-aligned, byte 0 in bits 7:0.
  // Code bit 0 puts red above blue; code bit 1 moves alpha to the bottom.
  function automatic logic [PIX_W-1:0] pack_px(input logic [CODE_W-1:0] code,
                                               input logic a_en, input logic a_inv,
                                               input logic [PIX_W-1:0] argb);
    logic [CODE_W-1:0] c;
    logic [CH_W-1:0] al, hi, gr, lo;
    c  = norm_code(code);
    al = alpha_eff(a_en, a_inv, argb[31:24]);
    gr = argb[15:8];
    hi = c[0] ? argb[23:16] : argb[7:0];
    lo = c[0] ? argb[7:0]   : argb[23:16];
    case (kind_of(code))
      FK_4444: pack_px = c[1] ? {16'd0, hi[7:4], gr[7:4], lo[7:4], al[7:4]}
                              : {16'd0, al[7:4], hi[7:4], gr[7:4], lo[7:4]};
      FK_565:  pack_px = {16'd0, hi[7:3], gr[7:2], lo[7:3]};
      FK_888:  pack_px = {8'd0, hi, gr, lo};
      default: pack_px = c[1] ? {hi, gr, lo, al} : {al, hi, gr, lo};
    endcase
  endfunction

endpackage

// File: rtl/wbpp_convert.sv
module wbpp_convert
  import wbpp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CODE_W-1:0]     cfg_fmt,
  input  logic                  cfg_alpha_en,
  input  logic                  cfg_alpha_inv,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [PIX_W-1:0]      in_argb,
  input  logic                  in_eol,
  output logic                  s_valid,
  input  logic                  s_take,
  output logic [PIX_W-1:0]      s_bytes,
  output logic [NB_W-1:0]       s_nbytes,
  output logic                  s_eol
);

  logic accept;

  assign in_ready = !s_valid || s_take;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid  <= 1'b0;
      s_bytes  <= '0;
      s_nbytes <= '0;
      s_eol    <= 1'b0;
    end else if (accept) begin
      s_valid  <= 1'b1;
      s_bytes  <= pack_px(cfg_fmt, cfg_alpha_en, cfg_alpha_inv, in_argb);
      s_nbytes <= nbytes_of(kind_of(cfg_fmt));
      s_eol    <= in_eol;
    end else if (s_take) begin
      s_valid  <= 1'b0;
    end
  end

  // R12: a converted pixel waiting for the gatherer is not lost or altered
  a_r12_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_take |=> s_valid && $stable(s_bytes) && $stable(s_eol));

endmodule

// File: rtl/wbpp_gather.sv
module wbpp_gather
  import wbpp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WORD_BYTES-1:0] cfg_byte_en,
  input  logic                  s_valid,
  output logic                  s_take,
  input  logic [PIX_W-1:0]      s_bytes,
  input  logic [NB_W-1:0]       s_nbytes,
  input  logic                  s_eol,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WORD_W-1:0]     out_data,
  output logic [WORD_BYTES-1:0] out_strb
);

  logic [ACC_W-1:0]  acc_q;
  logic [LEFT_W-1:0] cnt_q;
  logic              flush_q;

  logic [COMB_W-1:0] comb_w;
  logic [NB_W-1:0]   total;
  logic [NB_W-1:0]   rem;
  logic              full;
  logic              need_out;
  logic              out_free;
  // named events for the checks
  logic              flush_go;
  logic              emit_evt;
  logic [WORD_W-1:0] emit_data;
  logic [NB_W-1:0]   emit_nb;

  assign out_free = !out_valid || out_ready;
  assign comb_w   = {{WORD_W{1'b0}}, acc_q}
                  | ({{ACC_W{1'b0}}, s_bytes} << {cnt_q, 3'b000});
  assign total    = {1'b0, cnt_q} + s_nbytes;
  assign rem      = total - 3'd4;
  assign full     = total >= 3'd4;
  assign need_out = full || s_eol;
  assign s_take   = s_valid && !flush_q && (out_free || !need_out);
  assign flush_go = flush_q && out_free;
  assign emit_evt = flush_go || (s_take && need_out);
  assign emit_data = flush_go ? {8'd0, acc_q} : comb_w[WORD_W-1:0];
  assign emit_nb   = flush_go ? {1'b0, cnt_q} : (full ? 3'd4 : total);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_strb  <= '0;
    end else if (emit_evt) begin
      out_valid <= 1'b1;
      out_data  <= emit_data;
      out_strb  <= lane_mask(emit_nb) & cfg_byte_en;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else if (flush_go) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else if (s_take) begin
      if (full) begin
        acc_q   <= comb_w[COMB_W-1:WORD_W];
        cnt_q   <= rem[LEFT_W-1:0];
        flush_q <= s_eol && (rem != 3'd0);
      end else if (s_eol) begin
        acc_q   <= '0;
        cnt_q   <= '0;
      end else begin
        acc_q   <= comb_w[ACC_W-1:0];
        cnt_q   <= total[LEFT_W-1:0];
      end
    end
  end

  // R10: a pending tail is sent as soon as the output register frees
  a_r10_flush_next: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q && out_free |=> out_valid && !flush_q);

  // R10: a short word only ever closes a line
  a_r10_short_at_eol: assert property (@(posedge clk) disable iff (!rst_n)
    emit_evt && (emit_nb != 3'd4) |-> flush_go || s_eol);

  // R13: after a line closes without overflow, nothing is left behind
  a_r13_line_clean: assert property (@(posedge clk) disable iff (!rst_n)
    s_take && s_eol && !full |=> cnt_q == '0 && !flush_q);

endmodule

// File: rtl/wb_pixel_packer.sv
module wb_pixel_packer
  import wbpp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cfg_fmt,
  input  logic        cfg_alpha_en,
  input  logic        cfg_alpha_inv,
  input  logic [3:0]  cfg_byte_en,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_argb,
  input  logic        in_eol,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [3:0]  out_strb
);

  logic             s_valid;
  logic             s_take;
  logic [PIX_W-1:0] s_bytes;
  logic [NB_W-1:0]  s_nbytes;
  logic             s_eol;

  wbpp_convert u_convert (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_fmt       (cfg_fmt),
    .cfg_alpha_en  (cfg_alpha_en),
    .cfg_alpha_inv (cfg_alpha_inv),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_argb       (in_argb),
    .in_eol        (in_eol),
    .s_valid       (s_valid),
    .s_take        (s_take),
    .s_bytes       (s_bytes),
    .s_nbytes      (s_nbytes),
    .s_eol         (s_eol)
  );

  wbpp_gather u_gather (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_byte_en (cfg_byte_en),
    .s_valid     (s_valid),
    .s_take      (s_take),
    .s_bytes     (s_bytes),
    .s_nbytes    (s_nbytes),
    .s_eol       (s_eol),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_strb    (out_strb)
  );

  // R12: a waiting word stays put
  a_r12_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_strb));

  // R11: masked lanes never strobe
  a_r11_strb_mask: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_strb & ~cfg_byte_en) == 4'b0000);

endmodule

// File: tb/wb_pixel_packer_test.sv
module wb_pixel_packer_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_fmt = 4'd13;
  logic        cfg_alpha_en = 1'b1;
  logic        cfg_alpha_inv = 1'b0;
  logic [3:0]  cfg_byte_en = 4'hF;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_argb = '0;
  logic        in_eol = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [3:0]  out_strb;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0]  exp_b [0:63];
  logic [31:0] got_d [0:63];
  logic [3:0]  got_s [0:63];

  always #(CLK_P/2) clk = ~clk;

  wb_pixel_packer uut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_alpha_en(cfg_alpha_en),
    .cfg_alpha_inv(cfg_alpha_inv), .cfg_byte_en(cfg_byte_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_argb(in_argb), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_strb(out_strb)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference layout written per code, straight from the requirement text.
  function automatic void model_px(input logic [3:0] code, input bit ae, input bit ai,
                                   input logic [31:0] p, output logic [31:0] v,
                                   output int n);
    logic [7:0] a, r, g, b;
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    if (ae) a = ai ? ~p[31:24] : p[31:24];
    else    a = ai ? 8'h00 : 8'hFF;
    case (code)
      4'd0:  begin v = {16'd0, a[7:4], b[7:4], g[7:4], r[7:4]}; n = 2; end
      4'd1:  begin v = {16'd0, a[7:4], r[7:4], g[7:4], b[7:4]}; n = 2; end
      4'd2:  begin v = {16'd0, b[7:4], g[7:4], r[7:4], a[7:4]}; n = 2; end
      4'd3:  begin v = {16'd0, r[7:4], g[7:4], b[7:4], a[7:4]}; n = 2; end
      4'd6:  begin v = {16'd0, b[7:3], g[7:2], r[7:3]}; n = 2; end
      4'd7:  begin v = {16'd0, r[7:3], g[7:2], b[7:3]}; n = 2; end
      4'd8:  begin v = {8'd0, b, g, r}; n = 3; end
      4'd9:  begin v = {8'd0, r, g, b}; n = 3; end
      4'd12: begin v = {a, b, g, r}; n = 4; end
      4'd14: begin v = {b, g, r, a}; n = 4; end
      4'd15: begin v = {r, g, b, a}; n = 4; end
      default: begin v = {a, r, g, b}; n = 4; end
    endcase
  endfunction

  function automatic logic [31:0] pix_of(input int i, input int seed);
    return {8'(seed*37 + i*53 + 17), 8'(i*91 + seed*13 + 200),
            8'(i*29 + seed + 77), 8'(i*151 + seed*7 + 3)};
  endfunction

  // Stream one line and compare every word it produces.
  task automatic run_line(input string tag, input logic [3:0] code, input bit ae,
                          input bit ai, input logic [3:0] be, input int npix,
                          input int seed, input bit slow_out, input bit gaps);
    int nb = 0, nexp, idx = 0, got = 0, cyc = 0;
    bit presenting = 0, prev_stall = 0;
    logic [31:0] prev_d;
    logic [3:0]  prev_s;
    cfg_fmt = code; cfg_alpha_en = ae; cfg_alpha_inv = ai; cfg_byte_en = be;
    for (int i = 0; i < npix; i++) begin
      logic [31:0] v; int n;
      model_px(code, ae, ai, pix_of(i, seed), v, n);
      for (int k = 0; k < n; k++) begin exp_b[nb] = v[8*k +: 8]; nb++; end
    end
    nexp = (nb + 3) / 4;
    while ((idx < npix || got < nexp) && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      out_ready = slow_out ? (cyc % 3 != 1) : 1'b1;
      if (!presenting && idx < npix && !(gaps && cyc % 4 == 2)) begin
        in_argb = pix_of(idx, seed);
        in_eol  = (idx == npix - 1);
        presenting = 1;
      end
      in_valid = presenting;
      #1;
      if (prev_stall)  // R12 hold while stalled
        check(out_valid && out_data == prev_d && out_strb == prev_s,
              {tag, " R12 hold"}, out_data, prev_d);
      prev_stall = out_valid && !out_ready;
      prev_d = out_data; prev_s = out_strb;
      if (out_valid && out_ready) begin
        if (got < 64) begin got_d[got] = out_data; got_s[got] = out_strb; end
        got++;
      end
      if (in_valid && in_ready) begin idx++; presenting = 0; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_eol = 1'b0; out_ready = 1'b1;
    for (int w = 0; w < 4; w++) begin
      #1;
      if (out_valid) got++;
      @(negedge clk);
    end
    check(got == nexp, {tag, " word count"}, got, nexp);
    for (int w = 0; w < nexp && w < got && w < 64; w++) begin
      logic [3:0] es; logic [31:0] ed, m;
      for (int k = 0; k < 4; k++) begin
        es[k] = (4*w + k < nb) && be[k];
        ed[8*k +: 8] = (4*w + k < nb) ? exp_b[4*w + k] : 8'h00;
        m[8*k +: 8]  = {8{es[k]}};
      end
      check(got_s[w] == es, {tag, " strobe"}, {28'd0, got_s[w]}, {28'd0, es});
      check((got_d[w] & m) == (ed & m), {tag, " data"}, got_d[w] & m, ed & m);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_rgba32();
    run_line("R2 code12", 4'd12, 1, 0, 4'hF, 3, 1, 0, 0);
    run_line("R2 code13", 4'd13, 1, 0, 4'hF, 3, 2, 0, 0);
    run_line("R2 code14", 4'd14, 1, 0, 4'hF, 3, 3, 0, 0);
    run_line("R2 code15", 4'd15, 1, 0, 4'hF, 3, 4, 0, 0);
  endtask

  task automatic t_4444();
    for (int c = 0; c < 4; c++) run_line("R3 4444", 4'(c), 1, 0, 4'hF, 4, 10 + c, 0, 0);
  endtask

  task automatic t_565();
    run_line("R4 code6", 4'd6, 1, 0, 4'hF, 4, 20, 0, 0);
    run_line("R4 code7", 4'd7, 1, 0, 4'hF, 6, 21, 1, 0);
    run_line("R6 odd line", 4'd7, 1, 0, 4'hF, 3, 22, 0, 0);
  endtask

  task automatic t_888();
    run_line("R5 code9 4px", 4'd9, 1, 0, 4'hF, 4, 30, 0, 0);
    run_line("R5 code8 8px", 4'd8, 1, 0, 4'hF, 8, 31, 1, 1);
  endtask

  task automatic t_tail();
    run_line("R10 888 1px", 4'd9, 1, 0, 4'hF, 1, 40, 0, 0);
    run_line("R10 888 2px", 4'd9, 1, 0, 4'hF, 2, 41, 0, 0);
    run_line("R10 888 3px", 4'd8, 1, 0, 4'hF, 3, 42, 1, 0);
    run_line("R10 888 6px", 4'd9, 1, 0, 4'hF, 6, 43, 1, 1);
  endtask

  task automatic t_alpha();
    run_line("R7 inverted", 4'd15, 1, 1, 4'hF, 2, 50, 0, 0);
    run_line("R7 stored 4444", 4'd1, 1, 0, 4'hF, 2, 51, 0, 0);
    run_line("R8 fill ones", 4'd13, 0, 0, 4'hF, 2, 52, 0, 0);
    run_line("R8 fill zeros", 4'd3, 0, 1, 4'hF, 2, 53, 0, 0);
  endtask

  task automatic t_alias();
    run_line("R9 code4", 4'd4, 1, 0, 4'hF, 2, 60, 0, 0);
    run_line("R9 code5", 4'd5, 1, 0, 4'hF, 2, 61, 0, 0);
    run_line("R9 code10", 4'd10, 1, 0, 4'hF, 2, 62, 0, 0);
    run_line("R9 code11", 4'd11, 1, 1, 4'hF, 2, 63, 0, 0);
  endtask

  task automatic t_mask();
    run_line("R11 mask 1010", 4'd13, 1, 0, 4'b1010, 3, 70, 0, 0);
    run_line("R11 mask 0101 888", 4'd9, 1, 0, 4'b0101, 5, 71, 0, 0);
    run_line("R11 mask 0000", 4'd7, 1, 0, 4'b0000, 2, 72, 0, 0);
  endtask

  task automatic t_backpressure();
    run_line("R12 8888 slow", 4'd14, 1, 0, 4'hF, 9, 80, 1, 1);
    run_line("R12 4444 slow", 4'd2, 1, 1, 4'hF, 7, 81, 1, 0);
  endtask

  task automatic t_line_break();
    run_line("R13 first", 4'd9, 1, 0, 4'hF, 1, 90, 0, 0);
    run_line("R13 second", 4'd9, 1, 0, 4'hF, 1, 91, 0, 0);
    run_line("R13 after odd 16b", 4'd6, 1, 0, 4'hF, 3, 92, 0, 0);
    run_line("R13 next 16b", 4'd6, 1, 0, 4'hF, 2, 93, 0, 0);
  endtask

  initial begin
    t_reset();
    t_rgba32();
    t_4444();
    t_565();
    t_888();
    t_tail();
    t_alpha();
    t_alias();
    t_mask();
    t_backpressure();
    t_line_break();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule